// File: doc/BRIEF.md
# Interrupt Event Collector

This block gathers a set of event sources into one registered interrupt request line. Each source is fixed at elaboration as one of two kinds. A pulse source latches an event whenever its trigger input is high. A completion source latches an event when its trigger falls, which is how the end of a busy period is reported. Latched events stay set until software clears them through a small register port.

The register port has three per-source registers, with one bit per source in each. The status register shows the live trigger level of completion sources and cannot be written. The pending register holds the latched events and is cleared by writing ones. The enable register selects which pending events may raise the interrupt line. Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the pending and enable registers read zero, `irq` is low and the edge detector's stored trigger copy is zero.
- R2: A pulse source (its bit 0 in `LEVEL_SRC`) sets its pending bit at every clock edge where its trigger is high. The bit stays set after the trigger goes low and reads back 1 on the port after that edge.
- R3: A completion source (its bit 1 in `LEVEL_SRC`) sets its pending bit only at the edge following a high-to-low change of its trigger. A rising or steady-high trigger sets nothing.
- R4: Address 0 (status) reads the live trigger level on completion-source bits and 0 on pulse-source bits. Writes to address 0 change no register.
- R5: A write to address 1 (pending) clears every pending bit whose write-data bit is 1. Bits written 0 keep their value.
- R6: Address 2 (enable) is read-write. A write there loads all enable bits, and the enable bits hold their value when no enable write occurs.
- R7: `irq` is a register. It is high in the cycle after an edge at which some bit was both pending and enabled, and low in the cycle after an edge at which none was.
- R8: When a source's set condition and a software clear of the same bit occur at the same edge, the pending bit ends set.
- R9: Address 3 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | N_SRC | Trigger lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 pending, 2 enable |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
Each pending or enable change is visible on `reg_rdata` right after the clock edge that samples the trigger or the write. The status register follows `trig` with no delay. `irq` trails the pending-and-enabled condition by one more edge. The bench applies each vector in the low clock phase and lets one rising edge pass. Before the next falling edge it walks `reg_addr` across the registers to read the results, so every expected value is set for exactly one edge of latency, and `irq` is expected to show the condition from before that edge.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int          N_SRC     = 4,
  parameter logic [N_SRC-1:0] LEVEL_SRC = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] trig,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             irq
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_PEND = 2'd1;
  localparam logic [1:0] A_EN   = 2'd2;
  localparam logic [N_SRC-1:0] PULSE_SRC = ~LEVEL_SRC;

  logic [N_SRC-1:0] trig_q, pend_q, en_q, set_vec, clr_vec;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (LEVEL_SRC[i]) begin : g_lvl
      assign set_vec[i] = trig_q[i] & ~trig[i];
    end else begin : g_pls
      assign set_vec[i] = trig[i];
    end
  end

  assign clr_vec = (reg_wr && reg_addr == A_PEND) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      pend_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      trig_q <= trig;
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata;
      irq    <= |(pend_q & en_q);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = trig & LEVEL_SRC;
      A_PEND:  reg_rdata = pend_q;
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = '0;
    endcase
  end

  p_pulse_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & PULSE_SRC) != '0) |=>
      ((pend_q & $past(trig & PULSE_SRC)) == $past(trig & PULSE_SRC)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_fall_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_q & ~trig & LEVEL_SRC) != '0) |=>
      ((pend_q & $past(trig_q & ~trig & LEVEL_SRC)) == $past(trig_q & ~trig & LEVEL_SRC)));

  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PEND) |=> ((pend_q & $past(reg_wdata & ~set_vec)) == '0));

  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_EN) |=> $stable(en_q));

  p_irq_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & en_q) != '0) |=> irq);

  p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & en_q) == '0) |=> !irq);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((pend_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] trig = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl #(.N_SRC(4), .LEVEL_SRC(4'b1100)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {trig, wr, addr, wdata, exp_pend, exp_en, exp_irq, exp_stat, req}
  localparam logic [27:0] VEC [NV] = '{
    {4'b0000, 1'b1, 2'd2, 4'b1111, 4'b0000, 4'b1111, 1'b0, 4'b0000, 4'd6},  // R6
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b1111, 1'b0, 4'b0000, 4'd2},  // R2
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b1111, 1'b1, 4'b0000, 4'd2},  // R2 sticky
    {4'b0100, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b1111, 1'b1, 4'b0100, 4'd3},  // R3 rise
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0101, 4'b1111, 1'b1, 4'b0000, 4'd3},  // R3 fall
    {4'b0000, 1'b1, 2'd1, 4'b0001, 4'b0100, 4'b1111, 1'b1, 4'b0000, 4'd5},  // R5
    {4'b0000, 1'b1, 2'd1, 4'b0000, 4'b0100, 4'b1111, 1'b1, 4'b0000, 4'd5},  // R5 zeros
    {4'b0000, 1'b1, 2'd2, 4'b0000, 4'b0100, 4'b0000, 1'b1, 4'b0000, 4'd6},  // R6
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0100, 4'b0000, 1'b0, 4'b0000, 4'd7},  // R7
    {4'b1000, 1'b1, 2'd0, 4'b1111, 4'b0100, 4'b0000, 1'b0, 4'b1000, 4'd4},  // R4
    {4'b0000, 1'b1, 2'd3, 4'b1111, 4'b1100, 4'b0000, 1'b0, 4'b0000, 4'd9},  // R9
    {4'b0010, 1'b1, 2'd1, 4'b1100, 4'b0010, 4'b0000, 1'b0, 4'b0000, 4'd5},  // R5
    {4'b0010, 1'b1, 2'd1, 4'b0010, 4'b0010, 4'b0000, 1'b0, 4'b0000, 4'd8},  // R8 pulse
    {4'b0000, 1'b1, 2'd2, 4'b0010, 4'b0010, 4'b0010, 1'b0, 4'b0000, 4'd6},  // R6
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0010, 4'b0010, 1'b1, 4'b0000, 4'd7},  // R7
    {4'b1000, 1'b1, 2'd1, 4'b0010, 4'b0000, 4'b0010, 1'b1, 4'b1000, 4'd7},  // R7
    {4'b0000, 1'b1, 2'd1, 4'b1000, 4'b1000, 4'b0010, 1'b0, 4'b0000, 4'd8}   // R8 level
  };

  function automatic string rname(input int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [3:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  initial begin
    logic [3:0] v;
    #(CLK_PERIOD*2 + 2);
    rst_n = 1'b1;
    @(posedge clk); #1;
    read_reg(2'd1, v); check("R1", "pending", v, 4'b0000);
    read_reg(2'd2, v); check("R1", "enable", v, 4'b0000);
    check("R1", "irq", {3'b0, irq}, 4'b0000);
    read_reg(2'd3, v); check("R9", "addr3", v, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {trig, reg_wr, reg_addr, reg_wdata} = VEC[i][27:17];
      @(posedge clk); #1;
      reg_wr = 1'b0;
      read_reg(2'd1, v); check(rname(int'(VEC[i][3:0])), "pending", v, VEC[i][16:13]);
      read_reg(2'd2, v); check(rname(int'(VEC[i][3:0])), "enable", v, VEC[i][12:9]);
      read_reg(2'd0, v); check(rname(int'(VEC[i][3:0])), "status", v, VEC[i][7:4]);
      check(rname(int'(VEC[i][3:0])), "irq", {3'b0, irq}, {3'b0, VEC[i][8]});
    end

    // R9: address 3 still reads zero with registers nonzero
    read_reg(2'd3, v); check("R9", "addr3", v, 4'b0000);

    // R1: reset mid-run clears everything
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 4'b1111;
    @(negedge clk);
    reg_wr = 1'b0;
    rst_n = 1'b0;
    #1;
    read_reg(2'd1, v); check("R1", "pending", v, 4'b0000);
    read_reg(2'd2, v); check("R1", "enable", v, 4'b0000);
    check("R1", "irq", {3'b0, irq}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    miscompares++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule